// File: doc/BRIEF.md
# SPI Port Controller with Multi-Master Collision Detect

This block is one SPI port that either drives the bus as master or answers an outside master as slave. Each transfer moves a single character of 1 to 8 bits in both directions, most significant bit first. All four combinations of clock polarity and clock phase are available. As master, the port derives SCK from the system clock through a programmable divider. It starts a transfer when software writes the transmit register. As slave, it oversamples an external SCK, MOSI and active-low select through a synchronizer and acts on SCK edges in the system clock domain. The system clock must run at least four times faster than SCK.

Software reaches the block through a small parallel register port with a 2-bit address and separate write and read strobes. When the port is one of several masters on a shared bus, it watches its own select input. If another master pulls that input low, the port drops its SCK and MOSI drivers at once, aborts the character, and raises a sticky collision flag.

Top module: `serial_xchg`

## Requirements
- R1: The character length comes from control bits 7:5: a value of 0 means 8 bits and 1 to 7 mean that many bits. The master emits exactly that many SCK cycles. The received character lands right-aligned in the receive register (address 2 read), and the unused upper bits are zero.
- R2: While the port is an enabled master (control bit 0 enable, bit 1 master) and no transfer is running, SCK rests at the level of control bit 3 (clock polarity).
- R3: With control bit 4 (phase) at 0, the first bit is on the data line before the first SCK edge, input is sampled on each leading edge, and output changes on trailing edges. With phase at 1, output changes on leading edges and input is sampled on trailing edges. A master looped back onto itself therefore receives what it sent, in all four modes.
- R4: The master SCK period is 2*(D+1) system clocks, where D is the divider register at address 3.
- R5: As slave, the port shifts only while select is low. It drives MISO while selected. It reloads the transmit register (address 2 write) at each character boundary, including back-to-back characters with select held low.
- R6: As slave with select high, SCK and MOSI activity is ignored: the receive register and status do not change and MISO is not driven.
- R7: Status bit 0 (done) is set when the last bit of a character is sampled, and the character is stored. Done is cleared by reading the receive register or by writing 1 to status bit 0 (address 1).
- R8: Status bit 1 (overrun) is set when a character completes while done is still set and the receive register is not being read in that cycle. Writing 1 to status bit 1 clears it.
- R9: With control bit 2 (multi-master) set, select seen low while master sets status bit 2 (collision). In the same cycle the SCK and MOSI enables drop and the transfer aborts without setting done. The flag stays set, and new transfers are refused, until 1 is written to status bit 2. Status bit 3 reads busy.
- R10: When a character completes in the same cycle that the receive register is read, the read returns the previous character, done stays set and overrun is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divider |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Read strobe; consumes the receive register when address is 2 |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register |
| sckIn | input | 1 | SCK from an external master |
| sckOut | output | 1 | SCK driven as master |
| sckOe | output | 1 | SCK driver enable |
| mosiIn | input | 1 | Serial data in as slave |
| mosiOut | output | 1 | Serial data out as master |
| mosiOe | output | 1 | MOSI driver enable |
| misoIn | input | 1 | Serial data in as master |
| misoOut | output | 1 | Serial data out as slave |
| misoOe | output | 1 | MISO driver enable |
| ssN | input | 1 | Active-low select |

## Verification
The risky overlap is a character completing in the very cycle that software reads the receive register, because set and clear of the done flag then meet on one edge. The bench leaves one slave character unread. During the next character it raises the read strobe exactly when the final SCK edge leaves the synchronizer, by counting the two synchronizer stages and the edge detector from the moment it drives that edge. The result is judged on three points: the read must return the earlier character, done must remain set, and overrun must stay clear.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  localparam int CHAR_W = 8;
  localparam int CNT_W  = $clog2(CHAR_W);

  // control register layout, bit 0 = en
  typedef struct packed {
    logic [CNT_W-1:0] numBits;
    logic             phase;
    logic             clkPol;
    logic             multi;
    logic             master;
    logic             en;
  } ctrlReg_t;

  // strobes from sequencing control to the shift datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic capture;
  } xferStb_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  function automatic logic [CNT_W:0] charLen(input logic [CNT_W-1:0] nb);
    return (nb == '0) ? (CNT_W+1)'(CHAR_W) : (CNT_W+1)'(nb);
  endfunction
endpackage

// File: rtl/sxc_sync.sv
module sxc_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[0] <= RST_VAL;
        else       chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[i] <= RST_VAL;
        else       chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sxc_ctrl.sv
module sxc_ctrl import sxc_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlReg_t         ctrl,
  input  logic [DIV_W-1:0] divVal,
  input  logic             startReq,
  input  logic             colFlag,
  input  logic             sckS,
  input  logic             ssS,
  output xferStb_t         stb,
  output logic             sckLvl,
  output logic             busy,
  output logic             colDetect
);
  localparam int HALF_W = CNT_W + 1;

  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             sckPrev;
  logic [CNT_W:0]   nBits;
  logic [HALF_W-1:0] lastHalf;
  logic [CNT_W-1:0] lastBit;
  logic isMaster, isSlave, tick, start, sel, sckEdge;
  logic lead, trail, sampleEv, shiftEv, slaveIdle;

  always_comb begin
    nBits     = charLen(ctrl.numBits);
    lastHalf  = HALF_W'(2 * int'(nBits) - 1);
    lastBit   = CNT_W'(int'(nBits) - 1);
    isMaster  = ctrl.en & ctrl.master;
    isSlave   = ctrl.en & ~ctrl.master;
    slaveIdle = isSlave & ssS;
    colDetect = isMaster & ctrl.multi & ~ssS;
    tick      = running & (divCnt == divVal) & ~colDetect;
    start     = startReq & isMaster & ~running & ~colFlag & ~colDetect;
    sel       = isSlave & ~ssS;
    sckEdge   = sckS ^ sckPrev;
    if (isMaster) begin
      lead  = tick & ~halfCnt[0];
      trail = tick & halfCnt[0];
    end else begin
      lead  = sel & sckEdge & (sckS != ctrl.clkPol);
      trail = sel & sckEdge & (sckS == ctrl.clkPol);
    end
    sampleEv    = ctrl.phase ? trail : lead;
    shiftEv     = ctrl.phase ? lead : trail;
    stb.sample  = sampleEv;
    stb.capture = sampleEv & (bitCnt == lastBit);
    stb.shift   = shiftEv & (bitCnt != '0);
    stb.load    = (shiftEv & (bitCnt == '0)) | start | slaveIdle;
  end

  // sample counter: position inside the current character
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bitCnt  <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckPrev <= sckS;
      if (start || slaveIdle || colDetect || !ctrl.en) bitCnt <= '0;
      else if (sampleEv) bitCnt <= stb.capture ? '0 : bitCnt + 1'b1;
    end

  // master clock generator
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
      sckLvl  <= 1'b0;
    end else if (!isMaster || colDetect) begin
      running <= 1'b0;
      sckLvl  <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      divCnt  <= '0;
      halfCnt <= '0;
      sckLvl  <= 1'b0;
    end else if (tick) begin
      divCnt  <= '0;
      sckLvl  <= ~sckLvl;
      halfCnt <= halfCnt + 1'b1;
      if (halfCnt == lastHalf) running <= 1'b0;
    end else if (running) begin
      divCnt <= divCnt + 1'b1;
    end

  assign busy = running;
endmodule

// File: rtl/sxc_dpath.sv
module sxc_dpath import sxc_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [CHAR_W-1:0] regWrData,
  output logic [CHAR_W-1:0] regRdData,
  input  xferStb_t          stb,
  input  logic              bitIn,
  input  logic              busy,
  input  logic              colDetect,
  output ctrlReg_t          ctrl,
  output logic [DIV_W-1:0]  divVal,
  output logic              startReq,
  output logic              serOut,
  output logic              doneF,
  output logic              ovrF,
  output logic              colF
);
  logic [CHAR_W-1:0] txBuf, shiftQ, rxShift, rxData;
  logic [CHAR_W-1:0] loadSrc, aligned, rxNext, mask;
  logic [CNT_W:0]    nBits;
  logic wrData, rdRx, w1c;

  always_comb begin
    nBits   = charLen(ctrl.numBits);
    wrData  = regWr & (regAddr == ADDR_DATA);
    rdRx    = regRd & (regAddr == ADDR_DATA);
    w1c     = regWr & (regAddr == ADDR_STAT);
    loadSrc = wrData ? regWrData : txBuf;
    aligned = loadSrc << (CHAR_W - int'(nBits));
    rxNext  = {rxShift[CHAR_W-2:0], bitIn};
    mask    = {CHAR_W{1'b1}} >> (CHAR_W - int'(nBits));
  end

  assign startReq = wrData;
  assign serOut   = shiftQ[CHAR_W-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      ctrl   <= '0;
      divVal <= '0;
      txBuf  <= '0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_CTRL: ctrl   <= ctrlReg_t'(regWrData);
        ADDR_DIV:  divVal <= DIV_W'(regWrData);
        ADDR_DATA: txBuf  <= regWrData;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      shiftQ  <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (stb.load)       shiftQ <= aligned;
      else if (stb.shift) shiftQ <= shiftQ << 1;
      if (stb.sample)     rxShift <= rxNext;
      if (stb.capture)    rxData  <= rxNext & mask;
    end

  // sticky status flags, set beats clear
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      doneF <= 1'b0;
      ovrF  <= 1'b0;
      colF  <= 1'b0;
    end else begin
      if (stb.capture)                     doneF <= 1'b1;
      else if (rdRx || (w1c && regWrData[0])) doneF <= 1'b0;
      if (stb.capture && doneF && !rdRx)   ovrF <= 1'b1;
      else if (w1c && regWrData[1])        ovrF <= 1'b0;
      if (colDetect)                       colF <= 1'b1;
      else if (w1c && regWrData[2])        colF <= 1'b0;
    end

  always_comb
    case (regAddr)
      ADDR_CTRL: regRdData = CHAR_W'(ctrl);
      ADDR_STAT: regRdData = CHAR_W'({busy, colF, ovrF, doneF});
      ADDR_DATA: regRdData = rxData;
      default:   regRdData = CHAR_W'(divVal);
    endcase
endmodule

// File: rtl/serial_xchg.sv
module serial_xchg import sxc_pkg::*; #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        sckIn,
  output logic        sckOut,
  output logic        sckOe,
  input  logic        mosiIn,
  output logic        mosiOut,
  output logic        mosiOe,
  input  logic        misoIn,
  output logic        misoOut,
  output logic        misoOe,
  input  logic        ssN
);
  ctrlReg_t         ctrl;
  xferStb_t         stb;
  logic [DIV_W-1:0] divVal;
  logic [2:0]       syncQ;
  logic sckS, ssS, mosiS;
  logic startReq, sckLvl, busy, colDetect, colF, doneF, ovrF, serOut, bitIn, drive;

  sxc_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rstN(rstN), .d({sckIn, ssN, mosiIn}), .q(syncQ)
  );
  assign {sckS, ssS, mosiS} = syncQ;

  assign bitIn = ctrl.master ? misoIn : mosiS;

  sxc_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .divVal(divVal), .startReq(startReq),
    .colFlag(colF), .sckS(sckS), .ssS(ssS), .stb(stb), .sckLvl(sckLvl),
    .busy(busy), .colDetect(colDetect)
  );

  sxc_dpath #(.DIV_W(DIV_W)) dpath_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stb), .bitIn(bitIn),
    .busy(busy), .colDetect(colDetect), .ctrl(ctrl), .divVal(divVal),
    .startReq(startReq), .serOut(serOut), .doneF(doneF), .ovrF(ovrF), .colF(colF)
  );

  assign drive   = ctrl.en & ctrl.master & ~colF & ~colDetect;
  assign sckOut  = ctrl.clkPol ^ sckLvl;
  assign sckOe   = drive;
  assign mosiOut = serOut;
  assign mosiOe  = drive;
  assign misoOut = serOut;
  assign misoOe  = ctrl.en & ~ctrl.master & ~ssS;
endmodule

// File: rtl/sxc_chk.sv
module sxc_chk import sxc_pkg::*; (
  input logic     clk,
  input logic     rstN,
  input logic     cfgEn,
  input logic     cfgMaster,
  input logic     cfgPol,
  input xferStb_t stb,
  input logic     busy,
  input logic     sckOut,
  input logic     colF,
  input logic     doneF,
  input logic     ovrF,
  input logic     ssS,
  input logic     regWr,
  input logic     regRd,
  input logic [1:0] regAddr,
  input logic     wdCol
);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && cfgMaster && !busy) |-> (sckOut == cfgPol));

  p_load_xor_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.shift}));

  p_quiet_unselected_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && !cfgMaster && ssS) |-> !stb.sample);

  p_done_on_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> doneF);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && doneF && !(regRd && regAddr == ADDR_DATA)) |=> ovrF);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    colF |-> !busy);

  p_col_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (colF && !(regWr && regAddr == ADDR_STAT && wdCol)) |=> colF);
endmodule

bind serial_xchg sxc_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgEn(ctrl.en), .cfgMaster(ctrl.master),
  .cfgPol(ctrl.clkPol), .stb(stb), .busy(busy), .sckOut(sckOut), .colF(colF),
  .doneF(doneF), .ovrF(ovrF), .ssS(ssS), .regWr(regWr), .regRd(regRd),
  .regAddr(regAddr), .wdCol(regWrData[2])
);

// File: tb/serial_xchg_tb_top.sv
module serial_xchg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic clk = 0, rstN = 0;
  logic [1:0] regAddr = 0;
  logic regWr = 0, regRd = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic sckIn = 0, sckOut, sckOe, mosiIn = 0, mosiOut, mosiOe;
  logic misoOut, misoOe, ssN = 1, loop = 0;
  logic misoIn;
  assign misoIn = loop ? mosiOut : 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_xchg dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // SCK monitor for the master tests
  logic monPol = 0, prevSck = 0;
  int leadCnt = 0, cyc = 0, t1 = 0, t2 = 0;
  always @(negedge clk) begin
    cyc++;
    if (sckOut != prevSck && sckOut != monPol) begin
      leadCnt++;
      if (leadCnt == 1) t1 = cyc;
      if (leadCnt == 2) t2 = cyc;
    end
    prevSck = sckOut;
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic rxRead(output logic [7:0] d);
    @(negedge clk); regAddr = 2; regRd = 1; #1; d = regRdData;
    @(negedge clk); regRd = 0;
  endtask

  task automatic halfWait;
    repeat (H) @(negedge clk);
  endtask

  task automatic waitIdle;
    logic [7:0] s;
    for (int k = 0; k < 4000; k++) begin
      regRead(1, s);
      if (!s[3]) break;
    end
  endtask

  // read strobe timed to the cycle the final edge reaches the sampler
  task automatic readAtCapture(output logic [7:0] d);
    @(negedge clk); @(negedge clk);
    regAddr = 2; regRd = 1; #1; d = regRdData;
    @(negedge clk); regRd = 0;
  endtask

  task automatic slaveChar(input logic ph, input logic pol, input int n,
                           input logic [7:0] bits, input bit rdAtEnd,
                           output logic [7:0] got, output logic [7:0] rdOld);
    got = 0; rdOld = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!ph) begin
        mosiIn = bits[i]; halfWait;
        got = {got[6:0], misoOut};
        sckIn = ~pol;
        if (i == 0 && rdAtEnd) readAtCapture(rdOld);
        halfWait; sckIn = pol;
      end else begin
        sckIn = ~pol; mosiIn = bits[i]; halfWait;
        got = {got[6:0], misoOut};
        sckIn = pol;
        if (i == 0 && rdAtEnd) readAtCapture(rdOld);
        halfWait;
      end
    end
  endtask

  // {phase, pol, numBits, div, tx, expected rx}
  localparam logic [28:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd0, 8'd1, 8'hA5, 8'hA5},
    {1'b0, 1'b1, 3'd0, 8'd0, 8'h3C, 8'h3C},
    {1'b1, 1'b0, 3'd5, 8'd2, 8'hFF, 8'h1F},
    {1'b1, 1'b1, 3'd3, 8'd1, 8'h6D, 8'h05},
    {1'b0, 1'b0, 3'd1, 8'd0, 8'h81, 8'h01},
    {1'b1, 1'b1, 3'd7, 8'd3, 8'hC3, 8'h43}
  };

  initial begin
    logic [7:0] d, g1, g2, old;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    regRead(1, d); check("R7 status after reset", d, 8'h00);
    regRead(0, d); check("R2 control after reset", d, 8'h00);
    check("R9 sckOe after reset", sckOe, 0);
    check("R9 mosiOe after reset", mosiOe, 0);
    check("R6 misoOe after reset", misoOe, 0);

    // master loopback vectors
    loop = 1;
    for (int i = 0; i < 6; i++) begin
      logic ph, pol; logic [2:0] nb; logic [7:0] dv, tx, ex; int nbits;
      {ph, pol, nb, dv, tx, ex} = VEC[i];
      nbits = (nb == 0) ? 8 : int'(nb);
      monPol = pol;
      regWrite(0, {nb, ph, pol, 1'b0, 1'b1, 1'b1});
      regWrite(3, dv);
      regWrite(1, 8'h07);
      leadCnt = 0;
      regWrite(2, tx);
      waitIdle;
      regRead(1, d); check($sformatf("R7 done set v%0d", i), d[0], 1);
      rxRead(d); check($sformatf("R1 R3 loopback rx v%0d", i), d, ex);
      regRead(1, d); check($sformatf("R7 done cleared by read v%0d", i), d[0], 0);
      check($sformatf("R1 sck cycles v%0d", i), leadCnt, nbits);
      if (nbits > 1) check($sformatf("R4 sck period v%0d", i), t2 - t1, 2 * (int'(dv) + 1));
      check($sformatf("R2 idle level v%0d", i), sckOut, pol);
    end
    loop = 0;

    // slave, mode 0, 8 bits
    sckIn = 0;
    regWrite(0, 8'h01);
    regWrite(2, 8'h96);
    regWrite(1, 8'h07);
    ssN = 0; halfWait;
    check("R5 misoOe while selected", misoOe, 1);
    slaveChar(0, 0, 8, 8'h5A, 0, g1, old);
    halfWait; ssN = 1; halfWait;
    check("R5 slave miso char", g1, 8'h96);
    regRead(1, d); check("R7 slave done", d & 8'h0F, 8'h01);
    rxRead(d); check("R5 slave rx", d, 8'h5A);

    // slave back-to-back, phase 1, polarity 1, 4 bits, select held low
    sckIn = 1;
    regWrite(0, 8'h99);
    regWrite(2, 8'h0C);
    regWrite(1, 8'h07);
    ssN = 0; halfWait;
    slaveChar(1, 1, 4, 8'h0A, 0, g1, old);
    slaveChar(1, 1, 4, 8'h03, 0, g2, old);
    halfWait; ssN = 1; halfWait;
    check("R5 first char miso", g1, 8'h0C);
    check("R5 reload for second char", g2, 8'h0C);
    regRead(1, d); check("R8 overrun set", d & 8'h0F, 8'h03);
    rxRead(d); check("R1 R5 second char rx", d, 8'h03);
    regWrite(1, 8'h02);
    regRead(1, d); check("R8 overrun cleared", d & 8'h0F, 8'h00);

    // capture coinciding with rx read
    sckIn = 0;
    regWrite(0, 8'h01);
    regWrite(1, 8'h07);
    ssN = 0; halfWait;
    slaveChar(0, 0, 8, 8'h21, 0, g1, old);
    halfWait; ssN = 1; halfWait;
    ssN = 0; halfWait;
    slaveChar(0, 0, 8, 8'hB4, 1, g1, old);
    halfWait; ssN = 1; halfWait;
    check("R10 read returns previous", old, 8'h21);
    regRead(1, d); check("R10 done kept, no overrun", d & 8'h0F, 8'h01);
    rxRead(d); check("R10 new char stored", d, 8'hB4);

    // unselected slave ignores the bus
    regWrite(1, 8'h07);
    mosiIn = 1;
    for (int k = 0; k < 16; k++) begin halfWait; sckIn = ~sckIn; end
    halfWait;
    regRead(1, d); check("R6 status untouched", d & 8'h0F, 8'h00);
    regRead(2, d); check("R6 rx untouched", d, 8'hB4);
    check("R6 misoOe low", misoOe, 0);

    // multi-master collision
    sckIn = 0; loop = 1; monPol = 0;
    regWrite(0, 8'h07);
    regWrite(3, 8'd3);
    regWrite(1, 8'h07);
    regWrite(2, 8'h55);
    repeat (10) @(negedge clk);
    ssN = 0;
    repeat (4) @(negedge clk);
    check("R9 sckOe dropped", sckOe, 0);
    check("R9 mosiOe dropped", mosiOe, 0);
    regRead(1, d); check("R9 collision, aborted, no done", d & 8'h0F, 8'h04);
    ssN = 1;
    repeat (5) @(negedge clk);
    regWrite(2, 8'h55);
    regRead(1, d); check("R9 flag held, start refused", d & 8'h0F, 8'h04);
    regWrite(1, 8'h04);
    regRead(1, d); check("R9 flag cleared by write", d & 8'h0F, 8'h00);
    check("R9 drivers restored", sckOe, 1);
    loop = 0;

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule